// File: doc/BRIEF.md
# Multiplexed External Bus Timing Controller

This block turns single host requests into timed cycles on an external bus where address and data share the same wires. It serves up to three banks. Each bank has its own chip select pin and its own static settings: enable, bus width, chip-select polarity, continuous mode, clock divide, access length, hold length, hold-skip bits and idle gaps. Every phase on the pins is a whole number of bus clocks. A bus clock is the system clock divided by a power of two that each bank selects.

The host presents a bank index, an address, write data, a write flag and a byte-mode flag, and holds them with a valid flag until a one-cycle ready pulse comes back. On reads, the captured data is presented alongside that pulse. A full cycle runs in this order: address setup, the latch-enable pulse, latch hold, access, then hold, followed by an optional idle gap. A request that comes straight after the previous one can skip the three address phases, or be preceded by a read-to-read gap, as its bank settings dictate.

Top module: `xbus_timing_ctrl`

## Requirements
- R1: During and right after reset, the outputs sit at these levels: `req_ready` low, `bus_ale` low, `bus_rd_n` and `bus_wr_n` high, and `bus_ad_oe` low. Each `bus_cs` bit sits at its inactive level, which is 1 when that bank's `cfg_cs_hi` is 0 and 0 when it is 1.
- R2: Every phase lasts its bus-clock count times 2^`cfg_div` system clocks. `cfg_div` is the 3-bit field of the accessed bank and ranges from 0 to 7.
- R3: A normal cycle runs in this order, with these lengths in bus clocks:
  - setup: 1
  - latch pulse: `cfg_ale`+1, where the 3-bit `cfg_ale` is the single setting tied to bank 0 and shared by all banks
  - latch hold: 1
  - access: `cfg_acc`+1, where `cfg_acc` is 5 bits
  - hold: `cfg_hld`+1, where `cfg_hld` is 3 bits
  
  `bus_ale` is high only during the latch pulse, and the address is driven with `bus_ad_oe` high while it lasts. The chip select is active from setup through hold.
- R4: On a read, `bus_rd_n` is low exactly during the access phase. `rdata` is loaded from `bus_ad_in` on the last system clock of the access phase. When byte mode applies, `rdata[15:8]` is zero. Byte mode applies when `req_byte` is 1 or the bank's `cfg_wide` is 0.
- R5: On a write, `bus_wr_n` is low exactly during the access phase, and `bus_ad_out` carries the write data with `bus_ad_oe` high. When byte mode applies, the upper 8 data bits are driven as zero.
- R6: `cfg_rhold_off` removes the hold phase from reads, and `cfg_whold_off` removes it from writes.
- R7: After a write, the chip select stays inactive for `cfg_wgap` bus clocks before ready. A value of 0 adds no gap.
- R8: A read that directly follows a completed read starts with `cfg_rgap` bus clocks of inactive chip select. "Directly follows" means `req_valid` is high in the cycle right after the ready pulse.
- R9: A request that directly follows another to the same bank skips setup, latch pulse and latch hold when that bank's `cfg_cont` is 1.
- R10: Each bank's chip select is active low when its `cfg_cs_hi` is 0 and active high when it is 1. At most one chip select is active at a time.
- R11: A request to a bank whose `cfg_en` is 0, or to an index of 3 or more, gives ready in the cycle after acceptance and loads `rdata` with zero. It drives no strobe, no chip select and no latch pulse.
- R12: A request is accepted on a clock edge where `req_valid` is high, the block is idle, and ready is low. `req_ready` is high for exactly one cycle, the cycle after the final phase ends. A non-chained request therefore sees ready after (total phase clocks + 1) edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until ready |
| req_bank | input | 2 | Target bank index |
| req_addr | input | 16 | Address driven in the address phases |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | Byte mode request |
| req_ready | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data |
| cfg_en | input | 3 | Per-bank enable |
| cfg_wide | input | 3 | Per-bank 16-bit width select |
| cfg_cs_hi | input | 3 | Per-bank chip-select active level |
| cfg_cont | input | 3 | Per-bank continuous mode |
| cfg_rhold_off | input | 3 | Per-bank skip of hold on reads |
| cfg_whold_off | input | 3 | Per-bank skip of hold on writes |
| cfg_div | input | 3x3 | Per-bank clock divide exponent |
| cfg_acc | input | 3x5 | Per-bank access length minus one |
| cfg_hld | input | 3x3 | Per-bank hold length minus one |
| cfg_wgap | input | 3x4 | Per-bank idle after a write |
| cfg_rgap | input | 3x4 | Per-bank idle between reads |
| cfg_ale | input | 3 | Latch pulse length minus one (bank 0 setting) |
| bus_ale | output | 1 | Address latch enable |
| bus_cs | output | 3 | Chip selects |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad_out | output | 16 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | 16 | Multiplexed data in |

## Verification
A phase counter loaded with the wrong length, or with the wrong divide, changes the number of edges before `req_ready` within the same access. It is therefore caught on the first transaction that uses that setting. A wrong phase transition shows on the pins inside that access: a latch pulse that is missing or stretched, a strobe count that differs from the access length, or chip-select cycles that disagree with the expected total. A corrupted chaining or last-read flag does not show at once. It shows only on the next chained request, as a missing or extra gap, or as address phases that were skipped or kept wrongly. For that reason the bench issues chained pairs in both read and write form.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int DIV_W = 3;
    localparam int ALE_W = 3;
    localparam int ACC_W = 5;
    localparam int HLD_W = 3;
    localparam int GAP_W = 4;
    localparam int LANE  = 8;
    // longest phase: (2^ACC_W) bus clocks shifted by the largest divide
    localparam int CNT_W = ACC_W + 1 + (1 << DIV_W) - 1;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RGAP, PH_SETUP, PH_ALE, PH_LHOLD, PH_ACC, PH_HOLD, PH_WGAP
    } phase_e;

    typedef struct packed {
        logic             en;
        logic             wide;
        logic             cs_hi;
        logic             cont;
        logic             rhold_off;
        logic             whold_off;
        logic [DIV_W-1:0] div;
        logic [ACC_W-1:0] acc;
        logic [HLD_W-1:0] hld;
        logic [GAP_W-1:0] wgap;
        logic [GAP_W-1:0] rgap;
    } bank_cfg_t;

    // Length of a phase in system clocks.
    function automatic logic [CNT_W-1:0] phase_len(phase_e p, bank_cfg_t c,
                                                   logic [ALE_W-1:0] ale);
        logic [CNT_W-1:0] n;
        case (p)
            PH_RGAP:            n = CNT_W'(c.rgap);
            PH_SETUP, PH_LHOLD: n = CNT_W'(1);
            PH_ALE:             n = CNT_W'(ale) + CNT_W'(1);
            PH_ACC:             n = CNT_W'(c.acc) + CNT_W'(1);
            PH_HOLD:            n = CNT_W'(c.hld) + CNT_W'(1);
            PH_WGAP:            n = CNT_W'(c.wgap);
            default:            n = '0;
        endcase
        return n << c.div;
    endfunction

    function automatic phase_e after_hold(bank_cfg_t c, logic wr);
        return (wr && c.wgap != '0) ? PH_WGAP : PH_IDLE;
    endfunction

    function automatic phase_e after_access(bank_cfg_t c, logic wr);
        if (wr ? c.whold_off : c.rhold_off) return after_hold(c, wr);
        return PH_HOLD;
    endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int BW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [BW-1:0]    req_bank,
    input  logic             req_write,
    input  bank_cfg_t        cfg_sel,
    input  logic [ALE_W-1:0] ale_len,
    output phase_e           phase,
    output logic [BW-1:0]    cur_bank,
    output logic             cur_write,
    output logic             accept,
    output logic             dis_take,
    output logic             acc_last,
    output logic             ready
);

    logic [CNT_W-1:0] cnt;
    bank_cfg_t        cur_cfg;
    logic             ready_q, chain, last_rd, skip_q;
    logic             idle_take, skip, r2r;
    phase_e           first, nxt;

    assign idle_take = (phase == PH_IDLE) && !ready_q && req_valid;
    assign accept    = idle_take && cfg_sel.en;
    assign dis_take  = idle_take && !cfg_sel.en;
    assign skip      = chain && cfg_sel.cont && (req_bank == cur_bank);
    assign r2r       = chain && last_rd && !req_write && (cfg_sel.rgap != '0);
    assign first     = r2r ? PH_RGAP : (skip ? PH_ACC : PH_SETUP);
    assign acc_last  = (phase == PH_ACC) && (cnt == '0);
    assign ready     = ready_q;

    always_comb begin
        case (phase)
            PH_RGAP:  nxt = skip_q ? PH_ACC : PH_SETUP;
            PH_SETUP: nxt = PH_ALE;
            PH_ALE:   nxt = PH_LHOLD;
            PH_LHOLD: nxt = PH_ACC;
            PH_ACC:   nxt = after_access(cur_cfg, cur_write);
            PH_HOLD:  nxt = after_hold(cur_cfg, cur_write);
            default:  nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            cur_cfg   <= '0;
            cur_bank  <= '0;
            cur_write <= 1'b0;
            ready_q   <= 1'b0;
            chain     <= 1'b0;
            last_rd   <= 1'b0;
            skip_q    <= 1'b0;
        end else begin
            ready_q <= 1'b0;
            if (phase == PH_IDLE) begin
                if (!ready_q) begin
                    chain <= 1'b0;
                    if (accept) begin
                        phase     <= first;
                        cnt       <= phase_len(first, cfg_sel, ale_len) - CNT_W'(1);
                        cur_cfg   <= cfg_sel;
                        cur_bank  <= req_bank;
                        cur_write <= req_write;
                        skip_q    <= skip;
                    end else if (dis_take) begin
                        ready_q <= 1'b1;
                        last_rd <= 1'b0;
                    end
                end
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end else begin
                phase <= nxt;
                if (nxt == PH_IDLE) begin
                    ready_q <= 1'b1;
                    chain   <= 1'b1;
                    last_rd <= !cur_write;
                end else begin
                    cnt <= phase_len(nxt, cur_cfg, ale_len) - CNT_W'(1);
                end
            end
        end
    end

    // R12: completion pulse never lasts two cycles
    p_ready_single_r12: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);
    // R2: a running phase keeps its state until its count expires
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && cnt != '0) |=> $stable(phase));
    // R11: disabled target completes on the next edge
    p_disabled_fast_r11: assert property (@(posedge clk) disable iff (rst)
        dis_take |=> (ready && phase == PH_IDLE));

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int NBANK = 3,
    parameter int BW    = 2,
    parameter int ADW   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic [BW-1:0]    cur_bank,
    input  logic             cur_write,
    input  logic             cur_byte,
    input  logic [ADW-1:0]   addr,
    input  logic [ADW-1:0]   wdata,
    input  logic [NBANK-1:0] cs_hi,
    output logic             ale,
    output logic [NBANK-1:0] cs_o,
    output logic             rd_n,
    output logic             wr_n,
    output logic [ADW-1:0]   ad_out,
    output logic             ad_oe
);

    logic             in_cyc, addr_ph, data_ph;
    logic [NBANK-1:0] cs_act;
    logic [ADW-1:0]   wlane;

    assign addr_ph = (phase == PH_SETUP) || (phase == PH_ALE) || (phase == PH_LHOLD);
    assign data_ph = (phase == PH_ACC) || (phase == PH_HOLD);
    assign in_cyc  = addr_ph || data_ph;
    assign wlane   = cur_byte ? {{(ADW-LANE){1'b0}}, wdata[LANE-1:0]} : wdata;

    assign ale    = (phase == PH_ALE);
    assign rd_n   = !((phase == PH_ACC) && !cur_write);
    assign wr_n   = !((phase == PH_ACC) && cur_write);
    assign ad_oe  = addr_ph || (data_ph && cur_write);
    assign ad_out = addr_ph ? addr : ((data_ph && cur_write) ? wlane : '0);

    for (genvar b = 0; b < NBANK; b++) begin : g_cs
        assign cs_act[b] = in_cyc && (cur_bank == BW'(b));
        assign cs_o[b]   = cs_act[b] ? cs_hi[b] : !cs_hi[b];
    end

    // R10: at most one bank selected
    p_cs_single_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_act));
    // R3: latch pulse only inside an active chip select
    p_ale_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
        ale |-> $onehot(cs_act));
    // R4: read and write strobes never overlap
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    // R7: write gap keeps every chip select idle
    p_wgap_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WGAP) |-> (cs_act == '0));

endmodule

// File: rtl/xbus_timing_ctrl.sv
module xbus_timing_ctrl
    import xbus_pkg::*;
#(
    parameter int NBANK = 3,
    parameter int ADW   = 16,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK + 1) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [BW-1:0]               req_bank,
    input  logic [ADW-1:0]              req_addr,
    input  logic [ADW-1:0]              req_wdata,
    input  logic                        req_write,
    input  logic                        req_byte,
    output logic                        req_ready,
    output logic [ADW-1:0]              rdata,
    input  logic [NBANK-1:0]            cfg_en,
    input  logic [NBANK-1:0]            cfg_wide,
    input  logic [NBANK-1:0]            cfg_cs_hi,
    input  logic [NBANK-1:0]            cfg_cont,
    input  logic [NBANK-1:0]            cfg_rhold_off,
    input  logic [NBANK-1:0]            cfg_whold_off,
    input  logic [NBANK-1:0][DIV_W-1:0] cfg_div,
    input  logic [NBANK-1:0][ACC_W-1:0] cfg_acc,
    input  logic [NBANK-1:0][HLD_W-1:0] cfg_hld,
    input  logic [NBANK-1:0][GAP_W-1:0] cfg_wgap,
    input  logic [NBANK-1:0][GAP_W-1:0] cfg_rgap,
    input  logic [ALE_W-1:0]            cfg_ale,
    output logic                        bus_ale,
    output logic [NBANK-1:0]            bus_cs,
    output logic                        bus_rd_n,
    output logic                        bus_wr_n,
    output logic [ADW-1:0]              bus_ad_out,
    output logic                        bus_ad_oe,
    input  logic [ADW-1:0]              bus_ad_in
);

    bank_cfg_t        cfg_arr [NBANK];
    bank_cfg_t        cfg_sel;
    phase_e           phase;
    logic [BW-1:0]    cur_bank;
    logic             cur_write, accept, dis_take, acc_last;
    logic [ADW-1:0]   addr_q, wdata_q, rdata_q;
    logic             byte_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_cfg
        assign cfg_arr[b] = '{en: cfg_en[b], wide: cfg_wide[b], cs_hi: cfg_cs_hi[b],
                              cont: cfg_cont[b], rhold_off: cfg_rhold_off[b],
                              whold_off: cfg_whold_off[b], div: cfg_div[b],
                              acc: cfg_acc[b], hld: cfg_hld[b],
                              wgap: cfg_wgap[b], rgap: cfg_rgap[b]};
    end

    // out-of-range index selects an all-zero (disabled) setting
    always_comb begin
        cfg_sel = '0;
        for (int b = 0; b < NBANK; b++)
            if (req_bank == BW'(b)) cfg_sel = cfg_arr[b];
    end

    xbus_seq #(.BW(BW)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_write(req_write), .cfg_sel(cfg_sel), .ale_len(cfg_ale),
        .phase(phase), .cur_bank(cur_bank), .cur_write(cur_write),
        .accept(accept), .dis_take(dis_take), .acc_last(acc_last),
        .ready(req_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            byte_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                byte_q  <= req_byte || !cfg_sel.wide;
            end
            if (dis_take)
                rdata_q <= '0;
            else if (acc_last && !cur_write)
                rdata_q <= byte_q ? {{(ADW-LANE){1'b0}}, bus_ad_in[LANE-1:0]} : bus_ad_in;
        end
    end

    assign rdata = rdata_q;

    xbus_pins #(.NBANK(NBANK), .BW(BW), .ADW(ADW)) u_pins (
        .clk(clk), .rst(rst), .phase(phase), .cur_bank(cur_bank),
        .cur_write(cur_write), .cur_byte(byte_q), .addr(addr_q),
        .wdata(wdata_q), .cs_hi(cfg_cs_hi), .ale(bus_ale), .cs_o(bus_cs),
        .rd_n(bus_rd_n), .wr_n(bus_wr_n), .ad_out(bus_ad_out), .ad_oe(bus_ad_oe)
    );

    // R12: no new cycle starts in the ready cycle
    p_ready_idle_r12: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bus_rd_n && bus_wr_n && !bus_ale));

endmodule

// File: tb/xbus_timing_ctrl_tb.sv
module xbus_timing_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             req_valid = 0, req_write = 0, req_byte = 0;
    logic [1:0]       req_bank = 0;
    logic [15:0]      req_addr = 0, req_wdata = 0;
    logic             req_ready;
    logic [15:0]      rdata;
    logic [2:0]       cfg_en = 3'b111, cfg_wide = 3'b111, cfg_cs_hi = 3'b100;
    logic [2:0]       cfg_cont = 0, cfg_rhold_off = 0, cfg_whold_off = 0;
    logic [2:0][2:0]  cfg_div = '0, cfg_hld = '0;
    logic [2:0][4:0]  cfg_acc = '0;
    logic [2:0][3:0]  cfg_wgap = '0, cfg_rgap = '0;
    logic [2:0]       cfg_ale = 3'd2;
    logic             bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
    logic [2:0]       bus_cs;
    logic [15:0]      bus_ad_out, bus_ad_in, rd_val = 16'h0;

    assign bus_ad_in = bus_rd_n ? 16'hDEAD : rd_val;

    xbus_timing_ctrl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_byte(req_byte), .req_ready(req_ready), .rdata(rdata),
        .cfg_en(cfg_en), .cfg_wide(cfg_wide), .cfg_cs_hi(cfg_cs_hi),
        .cfg_cont(cfg_cont), .cfg_rhold_off(cfg_rhold_off),
        .cfg_whold_off(cfg_whold_off), .cfg_div(cfg_div), .cfg_acc(cfg_acc),
        .cfg_hld(cfg_hld), .cfg_wgap(cfg_wgap), .cfg_rgap(cfg_rgap),
        .cfg_ale(cfg_ale), .bus_ale(bus_ale), .bus_cs(bus_cs),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
    );

    int checks = 0, failures = 0;
    int r_edges, r_ale, r_cs, r_other, r_rd, r_wr;
    bit r_addr_ok, r_data_ok;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // total system clocks of phases, from the requirement formulas
    function automatic int exp_tot(int dv, int acc, int hld, bit nohold,
                                   int gap, bit cont);
        int bus = gap + (cont ? 0 : (1 + int'(cfg_ale) + 1 + 1)) + acc + 1
                  + (nohold ? 0 : hld + 1);
        return bus << dv;
    endfunction

    // caller is at a negedge; returns at the negedge where ready is seen
    task automatic run_txn(logic [1:0] bank, logic [15:0] addr, logic [15:0] wd,
                           bit wr, bit byt);
        logic [15:0] expd;
        bit eb;
        eb = byt || (bank < 3 && !cfg_wide[bank]);
        expd = eb ? {8'h00, wd[7:0]} : wd;
        req_bank = bank; req_addr = addr; req_wdata = wd;
        req_write = wr; req_byte = byt; req_valid = 1'b1;
        r_edges = 0; r_ale = 0; r_cs = 0; r_other = 0; r_rd = 0; r_wr = 0;
        r_addr_ok = 1; r_data_ok = 1;
        forever begin
            @(negedge clk);
            r_edges++;
            if (req_ready || r_edges > 5000) break;
            for (int b = 0; b < 3; b++)
                if (bus_cs[b] == cfg_cs_hi[b]) begin
                    if (b == int'(bank)) r_cs++; else r_other++;
                end
            if (bus_ale) begin
                r_ale++;
                if (bus_ad_out != addr || !bus_ad_oe) r_addr_ok = 0;
            end
            if (!bus_rd_n) r_rd++;
            if (!bus_wr_n) begin
                r_wr++;
                if (bus_ad_out != expd || !bus_ad_oe) r_data_ok = 0;
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(req_ready == 0 && bus_ale == 0 && bus_rd_n && bus_wr_n && !bus_ad_oe,
            "R1 strobes in reset", {req_ready, bus_ale, bus_rd_n, bus_wr_n}, 4'b0011);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_cs == 3'b011, "R1 R10 chip-select idle levels", bus_cs, 3'b011);
        chk(!req_ready && !bus_ad_oe, "R1 after release", {req_ready, bus_ad_oe}, 0);
    endtask

    task automatic t_basic_read;
        cfg_acc[0] = 3; cfg_hld[0] = 1; rd_val = 16'hA55A;
        run_txn(2'd0, 16'h1234, 16'h0, 0, 0);
        chk(r_edges == exp_tot(0, 3, 1, 0, 0, 0) + 1, "R3 R12 read edges", r_edges, 12);
        chk(r_ale == 3 && r_addr_ok, "R3 latch pulse/address", r_ale, 3);
        chk(r_cs == 11 && r_other == 0, "R3 chip select span", r_cs, 11);
        chk(r_rd == 4 && r_wr == 0, "R4 read strobe", r_rd, 4);
        chk(rdata == 16'hA55A, "R4 read data", rdata, 16'hA55A);
        @(negedge clk);
        chk(!req_ready, "R12 ready one cycle", req_ready, 0);
        idle(2);
    endtask

    task automatic t_div_write;
        cfg_div[1] = 1; cfg_acc[1] = 2; cfg_hld[1] = 0;
        run_txn(2'd1, 16'h0F0F, 16'hBEEF, 1, 0);
        chk(r_edges == exp_tot(1, 2, 0, 0, 0, 0) + 1, "R2 write edges div2", r_edges, 19);
        chk(r_ale == 6 && r_wr == 6 && r_rd == 0, "R2 R5 scaled strobes", r_wr, 6);
        chk(r_data_ok, "R5 write data on bus", r_data_ok, 1);
        idle(3);
        cfg_div[2] = 7; cfg_acc[2] = 0; cfg_hld[2] = 0; rd_val = 16'h1111;
        run_txn(2'd2, 16'h0001, 16'h0, 0, 0);
        chk(r_edges == exp_tot(7, 0, 0, 0, 0, 0) + 1, "R2 divide by 128", r_edges, 897);
        chk(r_ale == 384 && r_cs == 896, "R2 R10 active-high span", r_cs, 896);
        cfg_div[2] = 0;
        idle(3);
    endtask

    task automatic t_hold_off;
        cfg_rhold_off[0] = 1; rd_val = 16'h7E81;
        run_txn(2'd0, 16'h2222, 16'h0, 0, 0);
        chk(r_edges == exp_tot(0, 3, 1, 1, 0, 0) + 1, "R6 read hold skipped", r_edges, 10);
        chk(rdata == 16'h7E81, "R6 read data kept", rdata, 16'h7E81);
        cfg_rhold_off[0] = 0;
        idle(3);
        cfg_whold_off[1] = 1; cfg_hld[1] = 2;
        run_txn(2'd1, 16'h3333, 16'h4444, 1, 0);
        chk(r_edges == exp_tot(1, 2, 2, 1, 0, 0) + 1, "R6 write hold skipped", r_edges, 17);
        cfg_whold_off[1] = 0; cfg_hld[1] = 0;
        idle(3);
    endtask

    task automatic t_write_gap;
        cfg_acc[2] = 1; cfg_wgap[2] = 3;
        run_txn(2'd2, 16'h5555, 16'h9876, 1, 0);
        chk(r_edges == exp_tot(0, 1, 0, 0, 3, 0) + 1, "R7 gap before ready", r_edges, 12);
        chk(r_cs == 8 && r_wr == 2, "R7 chip select idle in gap", r_cs, 8);
        cfg_wgap[2] = 0;
        idle(3);
    endtask

    task automatic t_read_read;
        cfg_rgap[0] = 2; rd_val = 16'h0102;
        run_txn(2'd0, 16'h0010, 16'h0, 0, 0);
        chk(r_edges == 12, "R8 first read has no gap", r_edges, 12);
        rd_val = 16'h0304;
        run_txn(2'd0, 16'h0012, 16'h0, 0, 0);
        chk(r_edges == exp_tot(0, 3, 1, 0, 2, 0) + 2, "R8 chained read gap", r_edges, 15);
        chk(r_cs == 11 && r_rd == 4 && rdata == 16'h0304, "R8 chained read body", r_cs, 11);
        cfg_rgap[0] = 0;
        idle(3);
    endtask

    task automatic t_continuous;
        cfg_cont[1] = 1;
        run_txn(2'd1, 16'h0A00, 16'h1357, 1, 0);
        chk(r_edges == 19, "R9 first request full", r_edges, 19);
        run_txn(2'd1, 16'h0A02, 16'h2468, 1, 0);
        chk(r_edges == exp_tot(1, 2, 0, 0, 0, 1) + 2, "R9 chained skip", r_edges, 10);
        chk(r_ale == 0 && r_cs == 8 && r_wr == 6 && r_data_ok, "R9 no address phase",
            r_ale, 0);
        cfg_cont[1] = 0;
        idle(3);
    endtask

    task automatic t_disabled;
        cfg_en[1] = 0;
        run_txn(2'd1, 16'h0BAD, 16'h0, 0, 0);
        chk(r_edges == 1 && rdata == 16'h0, "R11 disabled bank", r_edges, 1);
        chk(r_cs == 0 && r_other == 0 && r_rd == 0 && r_ale == 0, "R11 no strobes",
            r_cs + r_other + r_rd, 0);
        cfg_en[1] = 1;
        idle(3);
        rd_val = 16'hFFFF;
        run_txn(2'd0, 16'h0, 16'h0, 0, 0);
        idle(3);
        run_txn(2'd3, 16'h0, 16'h0, 0, 0);
        chk(r_edges == 1 && rdata == 16'h0 && r_other == 0, "R11 index out of range",
            rdata, 0);
        idle(3);
    endtask

    task automatic t_byte;
        rd_val = 16'hC3B2;
        run_txn(2'd0, 16'h0040, 16'h0, 0, 1);
        chk(rdata == 16'h00B2, "R4 byte-mode read", rdata, 16'h00B2);
        idle(3);
        cfg_wide[2] = 0;
        run_txn(2'd2, 16'h0044, 16'hF00D, 1, 0);
        chk(r_data_ok && r_wr == 2, "R5 narrow bank write lanes", r_data_ok, 1);
        cfg_wide[2] = 1;
        idle(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_read();
        t_div_write();
        t_hold_off();
        t_write_gap();
        t_read_read();
        t_continuous();
        t_disabled();
        t_byte();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule